// File: doc/BRIEF.md
# Four-Way Page Translation Cache

This block sits between a requester that produces 14-bit virtual byte addresses and a page-table walker. Each page is 64 bytes, so a virtual address carries an 8-bit virtual page number (VPN) above a 6-bit byte offset. The block keeps 16 recent translations in 4 sets of 4 ways. All four ways of a set are compared in parallel. When a translation is cached, the block returns a 12-bit physical address on the cycle after the request is taken.

When no way matches, the block sends the VPN to the page-table port and holds that request until a response arrives. A response without a fault is written into the set and forwarded to the requester. A response with a fault is forwarded with a fault flag and leaves the cache unchanged. Only one table request can be outstanding at a time. A single-cycle invalidate input discards every cached translation.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `pt_req_valid` are 0, and no entry is valid, so the first access to any page goes to the page table.
- R2: The set index is virtual address bits 7:6, the tag is bits 13:8, and `pt_req_vpn` carries bits 13:6. An entry only matches in its own set, so address 0x03A9 (set 2, tag 0x03) misses while 0x03C0 (set 3, tag 0x03) is cached.
- R3: A request taken while a valid entry with a matching tag sits in the indexed set produces, one cycle later, `rsp_valid`=1, `rsp_hit`=1 and `rsp_paddr` = {stored PPN, vaddr[5:0]}, with no table request.
- R4: A request that misses raises `pt_req_valid` one cycle after it is taken. `pt_req_valid` and `pt_req_vpn` stay steady until the cycle that carries `pt_rsp_valid`. One cycle after that, the block gives `rsp_valid`=1 and `rsp_hit`=0.
- R5: A response with `pt_rsp_fault`=0 returns `rsp_paddr` = {`pt_rsp_ppn`, vaddr[5:0]} and installs the translation, so a later access to the same page hits at any offset.
- R6: A response with `pt_rsp_fault`=1 is passed on with `rsp_fault`=1 and installs nothing, so the next access to that page misses again.
- R7: On a fill, the victim is the lowest-numbered invalid way of the set.
- R8: When all four ways of a set are valid, a per-set 2-bit pointer picks the victim. The pointer starts at way 0 and advances by one after each such replacement.
- R9: From the cycle after a miss is taken until the table response is consumed, `req_ready` is 0, and requests presented in that window get no response and no table request.
- R10: A one-cycle pulse on `flush_all` invalidates every entry. If it coincides with a table response, the response is still forwarded but is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_all | input | 1 | Invalidate every cached translation |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 14 | Virtual byte address |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Result came from the cache |
| rsp_fault | output | 1 | Page table reported a fault |
| rsp_paddr | output | 12 | Physical byte address |
| pt_req_valid | output | 1 | Table lookup outstanding |
| pt_req_vpn | output | 8 | Page number to look up |
| pt_rsp_valid | input | 1 | Table response strobe |
| pt_rsp_fault | input | 1 | Table response is a fault |
| pt_rsp_ppn | input | 6 | Physical page number from the table |

## Verification
A cached result is due exactly one cycle after the request is taken. A table request is due one cycle after a missed request is taken. The forwarded result is due one cycle after the table response strobe. The bench drives each input on a falling edge. It then samples on the following falling edge: one rising edge later for a hit or a table request, and one rising edge after the response strobe for a refill. Every window between stimulus and result is therefore exact, never a range. While a refill is pending, the bench also samples each intermediate falling edge to confirm that no early result and no second table request appear.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tlb_state_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int SET_W = 2,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAYS-1:0]  wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  output logic [WAYS-1:0]  wr_set_valid
);
  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_mem [0:SETS-1][0:WAYS-1];
  logic [PPN_W-1:0] ppn_mem [0:SETS-1][0:WAYS-1];
  logic [WAYS-1:0]  valid_q [0:SETS-1];
  logic [WAYS-1:0]  way_hit;
  logic [SETS*WAYS-1:0] valid_flat;

  // Parallel compare across the ways of the indexed set
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = valid_q[rd_set][w] && (tag_mem[rd_set][w] == rd_tag);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_flat
    assign valid_flat[s*WAYS +: WAYS] = valid_q[s];
  end

  assign hit          = |way_hit;
  assign wr_set_valid = valid_q[wr_set];

  always_comb begin
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_ppn = hit_ppn | ppn_mem[rd_set][w];
    end
  end

  // Payload arrays carry no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wr_way[w]) begin
          tag_mem[wr_set][w] <= wr_tag;
          ppn_mem[wr_set][w] <= wr_ppn;
        end
      end
    end
  end

  // Invalidate wins over a fill in the same cycle
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= valid_q[wr_set] | wr_way;
    end
  end

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_flat == '0));

  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));

  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (valid_flat == '0));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int SET_W = 2,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic [WAYS-1:0]  set_valid,
  input  logic             fill,
  output logic [WAYS-1:0]  victim
);
  localparam int SETS  = 1 << SET_W;
  localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [PTR_W-1:0] rr_q [0:SETS-1];
  logic [WAYS-1:0]  first_free;
  logic             any_free;

  always_comb begin
    first_free = '0;
    any_free   = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!any_free && !set_valid[w]) begin
        first_free[w] = 1'b1;
        any_free      = 1'b1;
      end
    end
    victim = any_free ? first_free : (WAYS'(1) << rr_q[set_idx]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (fill && !any_free) begin
      rr_q[set_idx] <= rr_q[set_idx] + 1'b1;
    end
  end

  a_r8_victim_single: assert property (@(posedge clk) disable iff (rst)
    $countones(victim) == 1);

  a_r7_free_way_first: assert property (@(posedge clk) disable iff (rst)
    (set_valid != '1) |-> ((victim & set_valid) == '0));
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic lookup_hit,
  input  logic pt_rsp_valid,
  input  logic pt_rsp_fault,
  output logic req_ready,
  output logic waiting,
  output logic pt_req_valid,
  output logic rsp_valid,
  output logic rsp_hit,
  output logic rsp_fault
);
  tlb_state_e state_q;

  assign req_ready = (state_q == ST_IDLE);
  assign waiting   = (state_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pt_req_valid <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_fault    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (lookup_hit) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b1;
            end else begin
              state_q      <= ST_WAIT;
              pt_req_valid <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (pt_rsp_valid) begin
            state_q      <= ST_IDLE;
            pt_req_valid <= 1'b0;
            rsp_valid    <= 1'b1;
            rsp_fault    <= pt_rsp_fault;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r4_hold_lookup: assert property (@(posedge clk) disable iff (rst)
    (pt_req_valid && !pt_rsp_valid) |=> pt_req_valid);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    pt_req_valid |-> !req_ready);

  a_r4_refill_after_rsp: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> $past(pt_rsp_valid));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SET_W = 2,
  parameter int WAYS  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush_all,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_fault,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic                  pt_req_valid,
  output logic [VA_W-OFF_W-1:0] pt_req_vpn,
  input  logic                  pt_rsp_valid,
  input  logic                  pt_rsp_fault,
  input  logic [PA_W-OFF_W-1:0] pt_rsp_ppn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic             waiting;
  logic             accept;
  logic             refill_done;
  logic             install;
  logic [VPN_W-1:0] pend_vpn;
  logic [OFF_W-1:0] pend_off;
  logic [WAYS-1:0]  fill_valid;
  logic [WAYS-1:0]  fill_way;
  logic [PA_W-1:0]  paddr_q;

  assign accept      = req_valid && req_ready;
  assign refill_done = waiting && pt_rsp_valid;
  assign install     = refill_done && !pt_rsp_fault && !flush_all;
  assign pt_req_vpn  = pend_vpn;
  assign rsp_paddr   = paddr_q;

  tlb_store #(
    .SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)
  ) u_store (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush_all),
    .rd_set       (req_vaddr[OFF_W +: SET_W]),
    .rd_tag       (req_vaddr[OFF_W+SET_W +: TAG_W]),
    .hit          (lk_hit),
    .hit_ppn      (lk_ppn),
    .wr_en        (install),
    .wr_set       (pend_vpn[SET_W-1:0]),
    .wr_way       (fill_way),
    .wr_tag       (pend_vpn[VPN_W-1:SET_W]),
    .wr_ppn       (pt_rsp_ppn),
    .wr_set_valid (fill_valid)
  );

  tlb_victim #(
    .SET_W(SET_W), .WAYS(WAYS)
  ) u_victim (
    .clk       (clk),
    .rst       (rst),
    .set_idx   (pend_vpn[SET_W-1:0]),
    .set_valid (fill_valid),
    .fill      (install),
    .victim    (fill_way)
  );

  tlb_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .lookup_hit   (lk_hit),
    .pt_rsp_valid (pt_rsp_valid),
    .pt_rsp_fault (pt_rsp_fault),
    .req_ready    (req_ready),
    .waiting      (waiting),
    .pt_req_valid (pt_req_valid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_fault    (rsp_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vpn <= '0;
      pend_off <= '0;
      paddr_q  <= '0;
    end else begin
      if (accept) begin
        pend_vpn <= req_vaddr[VA_W-1:OFF_W];
        pend_off <= req_vaddr[OFF_W-1:0];
        if (lk_hit) paddr_q <= {lk_ppn, req_vaddr[OFF_W-1:0]};
      end else if (refill_done) begin
        paddr_q <= {pt_rsp_ppn, pend_off};
      end
    end
  end

  a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (accept && lk_hit) |=> (rsp_valid && rsp_hit && !pt_req_valid));

  a_r4_miss_requests: assert property (@(posedge clk) disable iff (rst)
    (accept && !lk_hit) |=> (pt_req_valid && !rsp_valid));

  a_r6_fault_not_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_valid && !rsp_hit));
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_all = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic        rsp_fault;
  logic [11:0] rsp_paddr;
  logic        pt_req_valid;
  logic [7:0]  pt_req_vpn;
  logic        pt_rsp_valid = 1'b0;
  logic        pt_rsp_fault = 1'b0;
  logic [5:0]  pt_rsp_ppn = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rst(rst), .flush_all(flush_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .pt_req_valid(pt_req_valid), .pt_req_vpn(pt_req_vpn),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_fault(pt_rsp_fault), .pt_rsp_ppn(pt_rsp_ppn)
  );

  // Vector: {vaddr[13:0], table fault, table ppn[5:0], expect hit, expect ppn[5:0]}
  localparam int NV = 24;
  localparam logic [27:0] VEC [0:NV-1] = '{
    {14'h03A9, 1'b0, 6'h11, 1'b0, 6'h11}, // 0  R1 empty: miss, R5 install
    {14'h03A9, 1'b0, 6'h00, 1'b1, 6'h11}, // 1  R3 hit
    {14'h03C0, 1'b0, 6'h0D, 1'b0, 6'h0D}, // 2  R2 same tag, set 3: miss
    {14'h0040, 1'b1, 6'h00, 1'b0, 6'h00}, // 3  R6 fault forwarded
    {14'h0045, 1'b0, 6'h17, 1'b0, 6'h17}, // 4  R6 not installed: miss again
    {14'h0040, 1'b0, 6'h00, 1'b1, 6'h17}, // 5  R5 other offset hits
    {14'h0481, 1'b0, 6'h21, 1'b0, 6'h21}, // 6  R7 set 2 way 1
    {14'h0582, 1'b0, 6'h22, 1'b0, 6'h22}, // 7  R7 way 2
    {14'h0683, 1'b0, 6'h23, 1'b0, 6'h23}, // 8  R7 way 3
    {14'h03A9, 1'b0, 6'h00, 1'b1, 6'h11}, // 9  all four coexist
    {14'h0582, 1'b0, 6'h00, 1'b1, 6'h22}, // 10
    {14'h0784, 1'b0, 6'h24, 1'b0, 6'h24}, // 11 R8 full: evicts way 0 (tag 03)
    {14'h0481, 1'b0, 6'h00, 1'b1, 6'h21}, // 12 way 1 survives
    {14'h03A9, 1'b0, 6'h11, 1'b0, 6'h11}, // 13 R8 gone; evicts way 1
    {14'h0481, 1'b0, 6'h31, 1'b0, 6'h31}, // 14 R8 gone; evicts way 2
    {14'h0683, 1'b0, 6'h00, 1'b1, 6'h23}, // 15 way 3 survives
    {14'h0784, 1'b0, 6'h00, 1'b1, 6'h24}, // 16
    {14'h03A9, 1'b0, 6'h00, 1'b1, 6'h11}, // 17
    {14'h0481, 1'b0, 6'h00, 1'b1, 6'h31}, // 18
    {14'h03C0, 1'b0, 6'h00, 1'b1, 6'h0D}, // 19 other set untouched
    {14'h3F3F, 1'b0, 6'h3F, 1'b0, 6'h3F}, // 20 R2 set 0, top tag
    {14'h3F3F, 1'b0, 6'h00, 1'b1, 6'h3F}, // 21 paddr 0xFFF
    {14'h0582, 1'b0, 6'h2A, 1'b0, 6'h2A}, // 22 R8 evicts way 3 (tag 06)
    {14'h0683, 1'b0, 6'h23, 1'b0, 6'h23}  // 23 R8 pointer wrapped
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // One request; on a miss the table answers after two idle cycles.
  task automatic xact(input logic [13:0] va, input logic pf, input logic [5:0] pp,
                      input logic eh, input logic [5:0] ep, input logic fl,
                      input string rq);
    @(negedge clk);
    chk(req_ready == 1'b1, rq, "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    if (eh) begin
      chk(rsp_valid && rsp_hit && !pt_req_valid, rq, "hit strobe",
          {rsp_valid, rsp_hit, pt_req_valid}, 3'b110);
      chk(rsp_paddr == {ep, va[5:0]}, rq, "hit paddr", rsp_paddr, {ep, va[5:0]});
    end else begin
      chk(pt_req_valid && !rsp_valid, rq, "miss lookup",
          {pt_req_valid, rsp_valid}, 2'b10);
      chk(pt_req_vpn == va[13:6], "R2", "lookup vpn", pt_req_vpn, va[13:6]);
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(pt_req_valid && !req_ready && !rsp_valid && pt_req_vpn == va[13:6],
            "R9", "hold while waiting",
            {pt_req_valid, req_ready, rsp_valid}, 3'b100);
      end
      pt_rsp_valid = 1'b1;
      pt_rsp_fault = pf;
      pt_rsp_ppn   = pp;
      flush_all    = fl;
      @(negedge clk);
      pt_rsp_valid = 1'b0;
      flush_all    = 1'b0;
      chk(rsp_valid && !rsp_hit && rsp_fault == pf && !pt_req_valid, "R4",
          "refill strobe", {rsp_valid, rsp_hit, rsp_fault, pt_req_valid},
          {1'b1, 1'b0, pf, 1'b0});
      if (!pf)
        chk(rsp_paddr == {ep, va[5:0]}, rq, "refill paddr", rsp_paddr, {ep, va[5:0]});
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !pt_req_valid, "R1", "reset outputs",
        {req_ready, rsp_valid, pt_req_valid}, 3'b100);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i][27:14], VEC[i][13], VEC[i][12:7], VEC[i][6], VEC[i][5:0],
           1'b0, $sformatf("R3/R5 vec%0d", i));
    end

    // R10 invalidate-all, then cached page misses
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    xact(14'h03C0, 1'b0, 6'h0D, 1'b0, 6'h0D, 1'b0, "R10 after flush");
    xact(14'h03C0, 1'b0, 6'h00, 1'b1, 6'h0D, 1'b0, "R10 refilled");

    // R10 invalidate coinciding with response: forwarded, not installed
    xact(14'h1200, 1'b0, 6'h05, 1'b0, 6'h05, 1'b1, "R10 flush on refill");
    xact(14'h1200, 1'b0, 6'h06, 1'b0, 6'h06, 1'b0, "R10 not installed");

    // R9 requests during a refill are ignored
    xact(14'h03C0, 1'b0, 6'h0D, 1'b0, 6'h0D, 1'b0, "R9 prime");
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = 14'h2240;
    @(negedge clk);
    req_vaddr = 14'h03C0;
    chk(pt_req_valid && !req_ready, "R9", "busy", {pt_req_valid, req_ready}, 2'b10);
    repeat (2) begin
      @(negedge clk);
      chk(!rsp_valid && pt_req_vpn == 8'h89, "R9", "no hit while busy",
          {rsp_valid, pt_req_vpn}, {1'b0, 8'h89});
    end
    pt_rsp_valid = 1'b1;
    pt_rsp_fault = 1'b0;
    pt_rsp_ppn   = 6'h07;
    @(negedge clk);
    pt_rsp_valid = 1'b0;
    req_valid    = 1'b0;
    chk(rsp_valid && rsp_paddr == 12'h1C0, "R9", "busy refill result",
        {rsp_valid, rsp_paddr}, {1'b1, 12'h1C0});
    @(negedge clk);
    chk(!rsp_valid && !pt_req_valid, "R9", "ignored request left no trace",
        {rsp_valid, pt_req_valid}, 2'b00);

    // R1 reset mid-run empties the cache
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    xact(14'h03C0, 1'b0, 6'h0E, 1'b0, 6'h0E, 1'b0, "R1 after reset");

    summary();
  end
endmodule